// File: doc/BRIEF.md
# Byte-Wide Double-Buffered DAC Front End

This block sits between an 8-bit microcontroller bus and a 12-bit string DAC. The host writes one byte at a time. A 2-bit address picks the target. The twelve code bits are split between a low-byte holding register and a high-nibble holding register. A separate 3-bit control register holds the mode bits. A write is accepted only on the rising edge of the active-low write strobe while the active-low chip select is low.

An active-low load input moves both holding registers into the 12-bit DAC code register in a single step, so the analog side never sees a half-updated code. The host can keep the load input low so that the code follows each write, or pulse it to update several DACs at the same moment. The block also drives a powerdown output and a fast-settling select. Each of these can be set either by a control bit or by a dedicated pin.

Top module: `bytedac_front`

## Requirements
- R1: A synchronous active-low reset clears both holding registers, the control register and the DAC code register to zero. After reset, `dac_code` is 0, `ctrl_rb` is 0, `fast_mode` follows only the speed pin, and `powerdown` follows only the powerdown pin.
- R2: A byte is stored only on the clock where the sampled `we_n` is high, `we_n` was low on the previous clock, and `cs_n` is low. Holding `we_n` low stores nothing. Address 0 targets the low-byte holding register, which holds `data[7:0]`.
- R3: Address 1 targets the high-nibble holding register, which stores `data[3:0]`. Data bits 7:4 have no effect.
- R4: Address 2 targets the control register, which stores `data[2:0]`. All three bits, including the reserved bit 2, appear unchanged on `ctrl_rb`.
- R5: A write to address 3 changes no register.
- R6: A write strobe edge while `cs_n` is high changes no register.
- R7: While `load_n` is high, `dac_code` holds its value, whatever writes take place.
- R8: On each clock where `load_n` is sampled low, `dac_code` takes {high nibble, low byte} from the holding registers. With `load_n` held low, a new byte appears on `dac_code` one clock after it is stored.
- R9: `powerdown` is 1 exactly when `pd_pin_n` is 0 or control bit 0 is 1.
- R10: `fast_mode` is 1 exactly when `speed_sel` is 1 or control bit 1 is 1. A 0 selects slow settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low; store on its rising edge |
| addr | input | 2 | Register select |
| data | input | 8 | Write data byte |
| load_n | input | 1 | Load holding registers into the code register, active low |
| pd_pin_n | input | 1 | Hardware powerdown request, active low |
| speed_sel | input | 1 | Hardware fast-mode request |
| dac_code | output | 12 | Code sent to the analog DAC |
| ctrl_rb | output | 3 | Control register contents |
| powerdown | output | 1 | Powerdown to the analog section |
| fast_mode | output | 1 | 1 selects fast settling, 0 selects slow |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, a 12-bit code, a 3-bit control register, and address map 0/1/2. These values make every address decode reachable, including the unused address 3. They also give a high nibble narrow enough that the ignored upper data bits show up directly in the code. With this build the bench covers both ways of using the load input: held low so the code follows writes, and pulsed after two holding writes that stayed invisible. The two mode outputs are driven from the pins and from the control bits in turn.

// File: rtl/bytedac_pkg.sv
// Shared types for the byte-wide DAC front end.
// Assumes: one register target per bus address; any other address is treated as no target.
package bytedac_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_LO   = 2'd1,
        TGT_HI   = 2'd2,
        TGT_CTRL = 2'd3
    } bytedac_tgt_e;
endpackage

// File: rtl/bytedac_wr_detect.sv
// Detects the rising edge of the active-low write strobe while chip select is low.
// Assumes: cs_n and we_n are already synchronous to clk.
// Produces a one-clock commit pulse.
module bytedac_wr_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic we_n,
    output logic wr_pulse
);
    logic we_n_q;

    // Remember last cycle's strobe level; reset to idle (high) so no false edge is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) we_n_q <= 1'b1;
        else        we_n_q <= we_n;
    end

    // Commit when the strobe goes from low to high and the chip is selected.
    always_comb wr_pulse = we_n & ~we_n_q & ~cs_n;
endmodule

// File: rtl/bytedac_regs.sv
// Holding, control and DAC code registers.
// Assumes: wr_pulse is one clock wide. Addresses that match no target are dropped.
// load_n is sampled on every clock: while it is low, the code register
// copies both holding registers together.
module bytedac_regs
    import bytedac_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CODE_W    = 12,
    parameter int CTRL_W    = 3,
    parameter int ADDR_W    = 2,
    parameter int ADDR_LO   = 0,
    parameter int ADDR_HI   = 1,
    parameter int ADDR_CTRL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              load_n,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [CODE_W-1:0] code_q
);
    localparam int HI_W = CODE_W - DATA_W;

    bytedac_tgt_e      tgt;
    logic [DATA_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;

    // Decode the bus address into a register target.
    always_comb begin
        if      (addr == ADDR_W'(ADDR_LO))   tgt = TGT_LO;
        else if (addr == ADDR_W'(ADDR_HI))   tgt = TGT_HI;
        else if (addr == ADDR_W'(ADDR_CTRL)) tgt = TGT_CTRL;
        else                                 tgt = TGT_NONE;
    end

    // Store the byte into the selected holding or control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            ctrl_q <= '0;
        end else if (wr_pulse) begin
            case (tgt)
                TGT_LO:   lo_q   <= data;
                TGT_HI:   hi_q   <= data[HI_W-1:0];
                TGT_CTRL: ctrl_q <= data[CTRL_W-1:0];
                default:  ;
            endcase
        end
    end

    // Copy both holding registers into the code register while load is low.
    always_ff @(posedge clk) begin
        if (!rst_n)       code_q <= '0;
        else if (!load_n) code_q <= {hi_q, lo_q};
    end
endmodule

// File: rtl/bytedac_mode.sv
// Merges the software mode bits with the hardware pins.
// Assumes: the powerdown pin is active low and the speed pin is active high.
// Either source alone is enough to assert its output.
module bytedac_mode (
    input  logic sw_pd,
    input  logic sw_fast,
    input  logic pd_pin_n,
    input  logic speed_sel,
    output logic powerdown,
    output logic fast_mode
);
    // Powerdown if the pin is pulled low or software asks for it.
    always_comb powerdown = ~pd_pin_n | sw_pd;
    // Fast settling if the pin or software asks for it.
    always_comb fast_mode = speed_sel | sw_fast;
endmodule

// File: rtl/bytedac_front.sv
// Top of the byte-wide double-buffered DAC front end.
// Assumes: every input is synchronous to clk, and reset is synchronous and active low.
module bytedac_front #(
    parameter int DATA_W    = 8,
    parameter int CODE_W    = 12,
    parameter int CTRL_W    = 3,
    parameter int ADDR_W    = 2,
    parameter int ADDR_LO   = 0,
    parameter int ADDR_HI   = 1,
    parameter int ADDR_CTRL = 2,
    parameter int PD_BIT    = 0,
    parameter int FAST_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              load_n,
    input  logic              pd_pin_n,
    input  logic              speed_sel,
    output logic [CODE_W-1:0] dac_code,
    output logic [CTRL_W-1:0] ctrl_rb,
    output logic              powerdown,
    output logic              fast_mode
);
    logic wr_pulse;

    bytedac_wr_detect i_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .wr_pulse (wr_pulse)
    );

    bytedac_regs #(
        .DATA_W    (DATA_W),
        .CODE_W    (CODE_W),
        .CTRL_W    (CTRL_W),
        .ADDR_W    (ADDR_W),
        .ADDR_LO   (ADDR_LO),
        .ADDR_HI   (ADDR_HI),
        .ADDR_CTRL (ADDR_CTRL)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_pulse (wr_pulse),
        .addr     (addr),
        .data     (data),
        .load_n   (load_n),
        .ctrl_q   (ctrl_rb),
        .code_q   (dac_code)
    );

    bytedac_mode i_mode (
        .sw_pd     (ctrl_rb[PD_BIT]),
        .sw_fast   (ctrl_rb[FAST_BIT]),
        .pd_pin_n  (pd_pin_n),
        .speed_sel (speed_sel),
        .powerdown (powerdown),
        .fast_mode (fast_mode)
    );
endmodule

// File: rtl/bytedac_front_chk.sv
// Property checker for bytedac_front, attached with bind.
module bytedac_front_chk #(
    parameter int ADDR_W = 2,
    parameter int CODE_W = 12,
    parameter int CTRL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              load_n,
    input logic              pd_pin_n,
    input logic              speed_sel,
    input logic [CODE_W-1:0] dac_code,
    input logic [CTRL_W-1:0] ctrl_rb,
    input logic              powerdown,
    input logic              fast_mode
);
    p_no_store_low_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n) |=> $stable(ctrl_rb));

    p_addr3_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(3)) |=> $stable(ctrl_rb));

    p_deselect_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(ctrl_rb));

    p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> $stable(dac_code));

    p_pin_pd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_pin_n || ctrl_rb[0]) |-> powerdown);

    p_pd_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        powerdown |-> (!pd_pin_n || ctrl_rb[0]));

    p_pin_fast_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_sel || ctrl_rb[1]) |-> fast_mode);

    p_fast_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fast_mode |-> (speed_sel || ctrl_rb[1]));
endmodule

bind bytedac_front bytedac_front_chk #(
    .ADDR_W (ADDR_W),
    .CODE_W (CODE_W),
    .CTRL_W (CTRL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .we_n      (we_n),
    .addr      (addr),
    .load_n    (load_n),
    .pd_pin_n  (pd_pin_n),
    .speed_sel (speed_sel),
    .dac_code  (dac_code),
    .ctrl_rb   (ctrl_rb),
    .powerdown (powerdown),
    .fast_mode (fast_mode)
);

// File: tb/test_bytedac_front.sv
// Scoreboard bench: the driver pushes expected outputs, the monitor compares them.
module test_bytedac_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        we_n = 1'b1;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  data = 8'd0;
    logic        load_n = 1'b1;
    logic        pd_pin_n = 1'b1;
    logic        speed_sel = 1'b0;
    logic [11:0] dac_code;
    logic [2:0]  ctrl_rb;
    logic        powerdown;
    logic        fast_mode;

    always #4 clk = ~clk;

    bytedac_front i_bytedac_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .addr(addr),
        .data(data), .load_n(load_n), .pd_pin_n(pd_pin_n), .speed_sel(speed_sel),
        .dac_code(dac_code), .ctrl_rb(ctrl_rb), .powerdown(powerdown),
        .fast_mode(fast_mode)
    );

    typedef struct {
        string       tag;
        logic [11:0] code;
        logic [2:0]  rb;
        logic        pd;
        logic        fast;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    logic [7:0]  m_lo = 0;
    logic [3:0]  m_hi = 0;
    logic [2:0]  m_ctrl = 0;
    logic [11:0] m_dac = 0;

    // Push the model's expected outputs for the current point in the run.
    task automatic expect_now(input string tag);
        exp_t e;
        e.tag  = tag;
        e.code = m_dac;
        e.rb   = m_ctrl;
        e.pd   = !pd_pin_n || m_ctrl[0];
        e.fast = speed_sel || m_ctrl[1];
        q.push_back(e);
    endtask

    // One bus write: strobe low, strobe high (commit), deselect, one extra clock.
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic cs);
        @(negedge clk); cs_n = cs; we_n = 1'b0; addr = a; data = d;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); cs_n = 1'b1; addr = 2'd0; data = 8'd0;
        @(negedge clk);
    endtask

    task automatic load_pulse();
        @(negedge clk); load_n = 1'b0;
        @(negedge clk); load_n = 1'b1;
    endtask

    // Monitor: compare each expected item just after it is pushed.
    initial begin
        forever begin
            wait (q.size() > 0);
            #1;
            begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (dac_code !== e.code || ctrl_rb !== e.rb ||
                    powerdown !== e.pd || fast_mode !== e.fast) begin
                    errors++;
                    $display("FAIL %s: got code=%h rb=%b pd=%b fast=%b, expected code=%h rb=%b pd=%b fast=%b",
                             e.tag, dac_code, ctrl_rb, powerdown, fast_mode,
                             e.code, e.rb, e.pd, e.fast);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R1 reset state");

        @(negedge clk); load_n = 1'b0;

        bus_write(2'd0, 8'hA5, 1'b0);
        m_lo = 8'hA5; m_dac = {m_hi, m_lo};
        expect_now("R2 R8 low byte write with load low");

        bus_write(2'd1, 8'hF3, 1'b0);
        m_hi = 4'h3; m_dac = {m_hi, m_lo};
        expect_now("R3 high nibble, upper bits ignored");

        bus_write(2'd2, 8'hFC, 1'b0);
        m_ctrl = 3'b100;
        expect_now("R4 reserved control bit read back");

        bus_write(2'd2, 8'h01, 1'b0);
        m_ctrl = 3'b001;
        expect_now("R9 software powerdown");

        bus_write(2'd2, 8'h02, 1'b0);
        m_ctrl = 3'b010;
        expect_now("R10 software fast mode");

        bus_write(2'd3, 8'hFF, 1'b0);
        expect_now("R5 address 3 ignored");

        bus_write(2'd0, 8'h00, 1'b1);
        bus_write(2'd2, 8'h00, 1'b1);
        expect_now("R6 chip select high ignored");

        // Strobe held low: nothing stored until it rises (R2).
        @(negedge clk); cs_n = 1'b0; we_n = 1'b0; addr = 2'd0; data = 8'h11;
        repeat (4) @(negedge clk);
        expect_now("R2 strobe held low stores nothing");
        we_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        m_lo = 8'h11; m_dac = {m_hi, m_lo};
        expect_now("R2 store on strobe rise");

        @(negedge clk); load_n = 1'b1;
        bus_write(2'd0, 8'h5C, 1'b0);
        bus_write(2'd1, 8'h07, 1'b0);
        m_lo = 8'h5C; m_hi = 4'h7;
        expect_now("R7 code held while load high");
        load_pulse();
        m_dac = {m_hi, m_lo};
        expect_now("R8 load pulse moves both halves");

        bus_write(2'd0, 8'h99, 1'b0);
        m_lo = 8'h99;
        expect_now("R7 no change without load");

        @(negedge clk); pd_pin_n = 1'b0;
        expect_now("R9 pin powerdown with control bit clear");
        bus_write(2'd2, 8'h00, 1'b0);
        m_ctrl = 3'b000;
        expect_now("R9 pin powerdown alone");
        @(negedge clk); pd_pin_n = 1'b1; speed_sel = 1'b1;
        expect_now("R10 pin fast mode alone");
        @(negedge clk); speed_sel = 1'b0;
        expect_now("R10 slow mode with pin and bit clear");

        bus_write(2'd2, 8'h07, 1'b0);
        m_ctrl = 3'b111;
        expect_now("R4 all control bits set");

        @(negedge clk); load_n = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_lo = 0; m_hi = 0; m_ctrl = 0; m_dac = 0;
        @(negedge clk);
        expect_now("R1 reset mid-run");

        wait (q.size() == 0);
        #2;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule